// File: doc/BRIEF.md
# Split Scratchpad and Packet Queue Memory

This block is the data memory of a small packet-handling core. It holds 256 words of 64 bits. The low half is scratch storage that the core reads and writes freely. The high half is a circular queue that hardware manages. Words arriving from the network are written into the queue, and queued words are streamed back out to the network. The core starts each receive or transmit with a one-cycle command strobe. It watches progress through the read and write offsets of the queue, which are always visible on output ports.

A receive command arms capture of exactly one packet. Incoming words fill consecutive queue slots, starting at the write offset. When the word flagged as the end of the packet arrives, the write offset jumps past the stored words and an arrival code is latched into a small interrupt register. The core reads that register with a strobe, and the read also clears it. A transmit command drains the queue one word per cycle until the read offset catches up with the write offset. The memory is split into two banks. As a result, the core conflicts with network traffic only when it touches the queue half, and in that case the core always wins.

Top module: `pktmem_top`

## Requirements
- R1: A core access with address bit 7 clear goes to the scratch half. A write stores `core_wdata` at `core_addr[6:0]`. A read returns the word on `core_rdata`, with `core_rvalid` high, in the cycle after the request.
- R2: Only `core_addr[7:0]` is decoded. Bits 15 to 8 have no effect on which word is accessed.
- R3: A `cmd_rx` pulse arms capture of one packet. Armed ingress words go to successive queue slots, beginning at `tail_ptr`. In the cycle after the word carrying `ing_eop`, `tail_ptr` has advanced by the number of words stored. While capture is not armed, ingress words change neither memory nor pointers.
- R4: A `cmd_tx` pulse streams the queued words out, oldest first. Each word appears on `egr_data` with `egr_valid` high, one per cycle, and `head_ptr` steps once per word. Streaming stops when `head_ptr` equals `tail_ptr`. A `cmd_tx` pulse on an empty queue produces no egress word.
- R5: `head_ptr` and `tail_ptr` are 7-bit slot offsets that wrap modulo 128. Queue slot k is also reachable by the core at address 128+k.
- R6: When a receive completes, the interrupt register is loaded with the arrival code (default 8'h01). An `irq_rd` pulse puts the register value on `irq_rdata` in the next cycle and clears the register. If a completion falls in the same cycle as the read, the completion wins and the code stays set.
- R7: The queue is full when the next write slot equals `head_ptr`, which gives a capacity of 127 words. An ingress word that meets a full queue is discarded, and the sticky flag `rx_overflow` is set until reset. If the end-of-packet word is discarded, the packet still closes on the words already stored.
- R8: A core write to the queue half in the same cycle as an armed ingress word wins: the ingress word is discarded and the slot is not consumed. A core read of the queue half pauses egress for that cycle without losing or reordering words.
- R9: After reset, both pointers are 0, the interrupt register and `irq_rdata` are 0, and `rx_overflow`, `egr_valid` and `core_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Core word address (low 8 bits decoded) |
| core_wdata | input | 64 | Core write data |
| core_rdata | output | 64 | Core read data |
| core_rvalid | output | 1 | Read data valid, one cycle after the request |
| cmd_rx | input | 1 | Arm capture of one packet |
| cmd_tx | input | 1 | Start draining the queue |
| ing_valid | input | 1 | Ingress word present |
| ing_data | input | 64 | Ingress word |
| ing_eop | input | 1 | Ingress word is the last of its packet |
| egr_valid | output | 1 | Egress word present |
| egr_data | output | 64 | Egress word |
| head_ptr | output | 7 | Queue read offset |
| tail_ptr | output | 7 | Queue write offset |
| irq_rd | input | 1 | Read-and-clear strobe for the interrupt register |
| irq_rdata | output | 8 | Value returned by the last interrupt read |
| rx_overflow | output | 1 | Sticky flag: an ingress word met a full queue |

## Verification
The main risk is a queue pointer that is wrong by one slot. That error shows up at the egress port within a single transmit: a word is repeated, skipped or stale, or the stream has the wrong length. Dropped or duplicated words are therefore caught by comparing each egress word in order against a queue of expected words. Receive bookkeeping errors are seen on `tail_ptr` one cycle after the end-of-packet word. An interrupt register that fails to clear, or that loses an arrival on a collision, shows on the very next read strobe.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;
  localparam int MEM_AW    = 8;
  localparam int PTR_W     = MEM_AW - 1;
  localparam int NUM_BANKS = 2;

  typedef logic [PTR_W-1:0] ptr_t;

  // next slot with natural wrap over the queue half
  function automatic ptr_t ptr_inc(ptr_t p);
    return p + ptr_t'(1);
  endfunction

  // one slot is kept free so that full and empty differ
  function automatic logic q_full(ptr_t wr, ptr_t rd);
    return ptr_inc(wr) == rd;
  endfunction

  // top address bit picks the queue half
  function automatic logic in_queue(logic [MEM_AW-1:0] a);
    return a[MEM_AW-1];
  endfunction
endpackage

// File: rtl/pktmem_bank.sv
module pktmem_bank #(
  parameter int DATA_W = 64,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pktmem_rx.sv
module pktmem_rx
  import pktmem_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rx,
  input  logic              ing_valid,
  input  logic [DATA_W-1:0] ing_data,
  input  logic              ing_eop,
  input  ptr_t              head,
  input  logic              core_blocks,
  output ptr_t              tail,
  output logic              wr_en,
  output ptr_t              wr_ptr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rx_done,
  output logic              drop_full,
  output logic              drop_core,
  output logic              overflow
);
  logic armed;
  logic accept;
  ptr_t close_ptr;

  assign accept    = armed && ing_valid;
  assign drop_full = accept && q_full(wr_ptr, head);
  assign drop_core = accept && !drop_full && core_blocks;
  assign wr_en     = accept && !drop_full && !core_blocks;
  assign wr_data   = ing_data;
  assign rx_done   = accept && ing_eop;
  assign close_ptr = wr_en ? ptr_inc(wr_ptr) : wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      tail     <= '0;
      wr_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (drop_full) overflow <= 1'b1;
      if (!armed) begin
        if (cmd_rx) begin
          armed  <= 1'b1;
          wr_ptr <= tail;
        end
      end else if (rx_done) begin
        armed  <= 1'b0;
        tail   <= close_ptr;
        wr_ptr <= close_ptr;
      end else if (wr_en) begin
        wr_ptr <= ptr_inc(wr_ptr);
      end
    end
  end
endmodule

// File: rtl/pktmem_tx.sv
module pktmem_tx
  import pktmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_tx,
  input  ptr_t tail,
  input  logic core_hold,
  output ptr_t head,
  output logic rd_en,
  output logic egr_valid
);
  logic active;
  logic pending;

  assign pending = head != tail;
  assign rd_en   = active && pending && !core_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      head      <= '0;
      egr_valid <= 1'b0;
    end else begin
      egr_valid <= rd_en;
      if (rd_en) head <= ptr_inc(head);
      if (!active) begin
        if (cmd_tx && pending) active <= 1'b1;
      end else if (!pending) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pktmem_irq.sv
module pktmem_irq #(
  parameter int               IRQ_W     = 8,
  parameter logic [IRQ_W-1:0] ARRIVE_ID = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_done,
  input  logic             irq_rd,
  output logic [IRQ_W-1:0] irq_q,
  output logic [IRQ_W-1:0] irq_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      irq_rdata <= '0;
    end else begin
      if (irq_rd) irq_rdata <= irq_q;
      if (rx_done)     irq_q <= ARRIVE_ID;
      else if (irq_rd) irq_q <= '0;
    end
  end
endmodule

// File: rtl/pktmem_top.sv
module pktmem_top
  import pktmem_pkg::*;
#(
  parameter int               DATA_W    = 64,
  parameter int               CORE_AW   = 16,
  parameter int               IRQ_W     = 8,
  parameter logic [IRQ_W-1:0] ARRIVE_ID = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_req,
  input  logic               core_we,
  input  logic [CORE_AW-1:0] core_addr,
  input  logic [DATA_W-1:0]  core_wdata,
  output logic [DATA_W-1:0]  core_rdata,
  output logic               core_rvalid,
  input  logic               cmd_rx,
  input  logic               cmd_tx,
  input  logic               ing_valid,
  input  logic [DATA_W-1:0]  ing_data,
  input  logic               ing_eop,
  output logic               egr_valid,
  output logic [DATA_W-1:0]  egr_data,
  output logic [PTR_W-1:0]   head_ptr,
  output logic [PTR_W-1:0]   tail_ptr,
  input  logic               irq_rd,
  output logic [IRQ_W-1:0]   irq_rdata,
  output logic               rx_overflow
);
  localparam int SCR = 0;
  localparam int QUE = 1;

  // address decode: upper core address bits are not part of the decode
  logic [MEM_AW-1:0]         core_lo;
  logic [CORE_AW-MEM_AW-1:0] unused_addr_hi;
  logic                      core_in_q;
  ptr_t                      core_off;
  logic                      core_fifo_wr;
  logic                      core_fifo_rd;
  logic                      core_scr_wr;
  logic                      core_scr_rd;

  assign core_lo        = core_addr[MEM_AW-1:0];
  assign unused_addr_hi = core_addr[CORE_AW-1:MEM_AW];
  assign core_in_q      = in_queue(core_lo);
  assign core_off       = core_lo[PTR_W-1:0];
  assign core_fifo_wr   = core_req &&  core_we &&  core_in_q;
  assign core_fifo_rd   = core_req && !core_we &&  core_in_q;
  assign core_scr_wr    = core_req &&  core_we && !core_in_q;
  assign core_scr_rd    = core_req && !core_we && !core_in_q;

  // receive path
  ptr_t              tail;
  ptr_t              head;
  logic              rx_wr_en;
  ptr_t              rx_wr_ptr;
  logic [DATA_W-1:0] rx_wr_data;
  logic              rx_done;
  logic              drop_full;
  logic              drop_core;
  logic              overflow;

  pktmem_rx #(.DATA_W(DATA_W)) rx_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_rx      (cmd_rx),
    .ing_valid   (ing_valid),
    .ing_data    (ing_data),
    .ing_eop     (ing_eop),
    .head        (head),
    .core_blocks (core_fifo_wr),
    .tail        (tail),
    .wr_en       (rx_wr_en),
    .wr_ptr      (rx_wr_ptr),
    .wr_data     (rx_wr_data),
    .rx_done     (rx_done),
    .drop_full   (drop_full),
    .drop_core   (drop_core),
    .overflow    (overflow)
  );

  // transmit path
  logic tx_issue;

  pktmem_tx tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_tx    (cmd_tx),
    .tail      (tail),
    .core_hold (core_fifo_rd),
    .head      (head),
    .rd_en     (tx_issue),
    .egr_valid (egr_valid)
  );

  // interrupt register
  logic [IRQ_W-1:0] irq_q;

  pktmem_irq #(.IRQ_W(IRQ_W), .ARRIVE_ID(ARRIVE_ID)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .irq_rd    (irq_rd),
    .irq_q     (irq_q),
    .irq_rdata (irq_rdata)
  );

  // two banks: scratch half and queue half
  logic              bank_we    [NUM_BANKS];
  ptr_t              bank_waddr [NUM_BANKS];
  logic [DATA_W-1:0] bank_wdata [NUM_BANKS];
  logic              bank_re    [NUM_BANKS];
  ptr_t              bank_raddr [NUM_BANKS];
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
  ptr_t              fifo_waddr;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    if (g == SCR) begin : g_scr
      assign bank_we[g]    = core_scr_wr;
      assign bank_waddr[g] = core_off;
      assign bank_wdata[g] = core_wdata;
      assign bank_re[g]    = core_scr_rd;
      assign bank_raddr[g] = core_off;
    end else begin : g_que
      // core wins both ports of the queue bank
      assign bank_we[g]    = core_fifo_wr || rx_wr_en;
      assign bank_waddr[g] = core_fifo_wr ? core_off : rx_wr_ptr;
      assign bank_wdata[g] = core_fifo_wr ? core_wdata : rx_wr_data;
      assign bank_re[g]    = core_fifo_rd || tx_issue;
      assign bank_raddr[g] = core_fifo_rd ? core_off : head;
    end

    pktmem_bank #(.DATA_W(DATA_W), .AW(PTR_W)) mem_i (
      .clk   (clk),
      .we    (bank_we[g]),
      .waddr (bank_waddr[g]),
      .wdata (bank_wdata[g]),
      .re    (bank_re[g]),
      .raddr (bank_raddr[g]),
      .rdata (bank_rdata[g])
    );
  end

  assign fifo_waddr = bank_waddr[QUE];

  // core read return path
  logic core_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rvalid <= 1'b0;
      core_sel_q  <= 1'b0;
    end else begin
      core_rvalid <= core_req && !core_we;
      if (core_req && !core_we) core_sel_q <= core_in_q;
    end
  end

  assign core_rdata  = core_sel_q ? bank_rdata[QUE] : bank_rdata[SCR];
  assign egr_data    = bank_rdata[QUE];
  assign head_ptr    = head;
  assign tail_ptr    = tail;
  assign rx_overflow = overflow;
endmodule

// File: rtl/pktmem_chk.sv
module pktmem_chk
  import pktmem_pkg::*;
#(
  parameter int               IRQ_W     = 8,
  parameter logic [IRQ_W-1:0] ARRIVE_ID = 8'h01
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_done,
  input ptr_t             tail,
  input ptr_t             head,
  input logic             tx_issue,
  input logic             irq_rd,
  input logic [IRQ_W-1:0] irq_q,
  input logic             drop_full,
  input logic             drop_core,
  input logic             overflow,
  input logic             core_fifo_wr,
  input ptr_t             core_off,
  input ptr_t             fifo_waddr,
  input logic             core_fifo_rd,
  input logic             egr_valid
);
  a_r3_tail_moves_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(tail));

  a_r4_head_steps_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    tx_issue |=> head == ptr_inc($past(head)));

  a_r4_head_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_issue |=> $stable(head));

  a_r6_arrival_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> irq_q == ARRIVE_ID);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && !rx_done) |=> irq_q == '0);

  a_r7_full_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drop_full |=> overflow);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_core_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    core_fifo_wr |-> fifo_waddr == core_off);

  a_r8_collision_drop: assert property (@(posedge clk) disable iff (!rst_n)
    drop_core |-> core_fifo_wr);

  a_r8_egress_pauses: assert property (@(posedge clk) disable iff (!rst_n)
    core_fifo_rd |=> !egr_valid);
endmodule

bind pktmem_top pktmem_chk #(.IRQ_W(IRQ_W), .ARRIVE_ID(ARRIVE_ID)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_done      (rx_done),
  .tail         (tail),
  .head         (head),
  .tx_issue     (tx_issue),
  .irq_rd       (irq_rd),
  .irq_q        (irq_q),
  .drop_full    (drop_full),
  .drop_core    (drop_core),
  .overflow     (overflow),
  .core_fifo_wr (core_fifo_wr),
  .core_off     (core_off),
  .fifo_waddr   (fifo_waddr),
  .core_fifo_rd (core_fifo_rd),
  .egr_valid    (egr_valid)
);

// File: tb/pktmem_top_tb_top.sv
module pktmem_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [15:0] core_addr = '0;
  logic [63:0] core_wdata = '0;
  logic [63:0] core_rdata;
  logic        core_rvalid;
  logic        cmd_rx = 1'b0, cmd_tx = 1'b0;
  logic        ing_valid = 1'b0, ing_eop = 1'b0;
  logic [63:0] ing_data = '0;
  logic        egr_valid;
  logic [63:0] egr_data;
  logic [6:0]  head_ptr, tail_ptr;
  logic        irq_rd = 1'b0;
  logic [7:0]  irq_rdata;
  logic        rx_overflow;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q [$];

  always #5 clk = ~clk;

  pktmem_top dut_i (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_rvalid(core_rvalid), .cmd_rx(cmd_rx), .cmd_tx(cmd_tx),
    .ing_valid(ing_valid), .ing_data(ing_data), .ing_eop(ing_eop),
    .egr_valid(egr_valid), .egr_data(egr_data), .head_ptr(head_ptr),
    .tail_ptr(tail_ptr), .irq_rd(irq_rd), .irq_rdata(irq_rdata),
    .rx_overflow(rx_overflow)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare egress stream against the scoreboard queue (R4)
  always @(negedge clk) begin
    if (rst_n && egr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected egress word", egr_data, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check(egr_data === e, "R4 egress word", egr_data, e);
      end
    end
  end

  task automatic core_write(input logic [15:0] a, input logic [63:0] d);
    core_req = 1'b1; core_we = 1'b1; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_req = 1'b0; core_we = 1'b0;
  endtask

  task automatic core_read(input logic [15:0] a, output logic [63:0] d, output logic v);
    core_req = 1'b1; core_we = 1'b0; core_addr = a;
    @(negedge clk);
    core_req = 1'b0;
    d = core_rdata; v = core_rvalid;
  endtask

  task automatic send_word(input logic [63:0] d, input logic eop, input logic expect_out);
    ing_valid = 1'b1; ing_data = d; ing_eop = eop;
    if (expect_out) exp_q.push_back(d);
    @(negedge clk);
    ing_valid = 1'b0; ing_eop = 1'b0;
  endtask

  task automatic pulse_rx();
    cmd_rx = 1'b1; @(negedge clk); cmd_rx = 1'b0;
  endtask

  task automatic pulse_tx();
    cmd_tx = 1'b1; @(negedge clk); cmd_tx = 1'b0;
  endtask

  task automatic irq_read(output logic [7:0] v);
    irq_rd = 1'b1; @(negedge clk); irq_rd = 1'b0;
    v = irq_rdata;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        rv;
    logic [7:0]  iv;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(head_ptr == 0 && tail_ptr == 0, "R9 pointers at reset", {head_ptr, tail_ptr}, 0);
    check(!egr_valid && !core_rvalid && !rx_overflow, "R9 flags at reset",
          {egr_valid, core_rvalid, rx_overflow}, 0);
    check(irq_rdata == 0, "R9 irq_rdata at reset", irq_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 scratch half
    core_write(16'h0005, 64'h1111_2222_3333_4444);
    core_write(16'h007F, 64'hAAAA_BBBB_CCCC_DDDD);
    core_read(16'h0005, rd, rv);
    check(rv && rd == 64'h1111_2222_3333_4444, "R1 scratch read slot 5", rd, 64'h1111_2222_3333_4444);
    core_read(16'h007F, rd, rv);
    check(rd == 64'hAAAA_BBBB_CCCC_DDDD, "R1 scratch read slot 127", rd, 64'hAAAA_BBBB_CCCC_DDDD);

    // R2 upper address bits ignored
    core_write(16'hAB06, 64'h0606_0606_0606_0606);
    core_read(16'h0006, rd, rv);
    check(rd == 64'h0606_0606_0606_0606, "R2 truncated write", rd, 64'h0606_0606_0606_0606);
    core_read(16'h5A05, rd, rv);
    check(rd == 64'h1111_2222_3333_4444, "R2 truncated read", rd, 64'h1111_2222_3333_4444);

    // R3 unarmed ingress ignored
    send_word(64'hDEAD, 1'b1, 1'b0);
    @(negedge clk);
    check(tail_ptr == 0, "R3 unarmed ingress tail", tail_ptr, 0);
    irq_read(iv);
    check(iv == 0, "R3 unarmed ingress no arrival", iv, 0);

    // R3 three-word packet
    pulse_rx();
    send_word(64'h100, 1'b0, 1'b1);
    send_word(64'h101, 1'b0, 1'b1);
    send_word(64'h102, 1'b1, 1'b1);
    check(tail_ptr == 3, "R3 tail after packet", tail_ptr, 3);
    check(head_ptr == 0, "R3 head unchanged", head_ptr, 0);

    // R6 read and clear
    irq_read(iv);
    check(iv == 8'h01, "R6 arrival code", iv, 8'h01);
    irq_read(iv);
    check(iv == 8'h00, "R6 cleared by read", iv, 8'h00);

    // R5 queue slot via core address 128+k
    core_read(16'h0081, rd, rv);
    check(rd == 64'h101, "R5 core view of slot 1", rd, 64'h101);

    // R4 transmit
    pulse_tx();
    drain("R4 drain first packet");
    check(head_ptr == 3, "R4 head meets tail", head_ptr, 3);

    // R4 empty transmit: monitor flags any word
    pulse_tx();
    repeat (5) @(negedge clk);
    check(head_ptr == 3, "R4 empty transmit head", head_ptr, 3);

    // R8 core write wins over ingress
    pulse_rx();
    send_word(64'h200, 1'b0, 1'b1);
    ing_valid = 1'b1; ing_data = 64'h201; ing_eop = 1'b0;
    core_req = 1'b1; core_we = 1'b1; core_addr = 16'h00C8; core_wdata = 64'hC8C8;
    @(negedge clk);
    ing_valid = 1'b0; core_req = 1'b0; core_we = 1'b0;
    send_word(64'h202, 1'b1, 1'b1);
    check(tail_ptr == 5, "R8 collided word not stored", tail_ptr, 5);

    // R8 core read pauses egress, stream still ordered
    pulse_tx();
    core_read(16'h00C8, rd, rv);
    check(rd == 64'hC8C8, "R8 core write landed", rd, 64'hC8C8);
    drain("R8 drain after pause");
    check(head_ptr == 5, "R8 head after drain", head_ptr, 5);
    irq_read(iv);

    // R7 overflow: 130 words into 127 free slots
    pulse_rx();
    for (int i = 0; i < 130; i++) send_word(64'hF000 + 64'(i), i == 129, i < 127);
    check(tail_ptr == 4, "R7 tail after full packet", tail_ptr, 4);
    check(rx_overflow == 1'b1, "R7 overflow flag", rx_overflow, 1);
    pulse_tx();
    drain("R7 drain full queue");
    check(head_ptr == 4, "R5 head wrapped", head_ptr, 4);
    check(rx_overflow == 1'b1, "R7 overflow sticky", rx_overflow, 1);

    // R6 arrival collides with read: arrival wins
    irq_read(iv);
    check(iv == 8'h01, "R6 code after overflow packet", iv, 8'h01);
    pulse_rx();
    ing_valid = 1'b1; ing_data = 64'h300; ing_eop = 1'b1; irq_rd = 1'b1;
    exp_q.push_back(64'h300);
    @(negedge clk);
    ing_valid = 1'b0; ing_eop = 1'b0; irq_rd = 1'b0;
    check(irq_rdata == 8'h00, "R6 read value on collision", irq_rdata, 8'h00);
    irq_read(iv);
    check(iv == 8'h01, "R6 arrival kept on collision", iv, 8'h01);
    check(tail_ptr == 5, "R3 single word packet", tail_ptr, 5);
    pulse_tx();
    drain("R4 drain single word");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule